// File: doc/BRIEF.md
# Previous-Frame Block Cache Controller

This block manages an on-chip copy of the last fully decoded frame so that motion-compensation fetches which point at that frame can be answered without going to external memory. The frame is kept at macroblock granularity: one storage slot per macroblock position, addressed by the raster index `y * MB_COLS + x`. Each newly decoded block is forwarded to the external write port at once. The block is also placed in a small first-in first-out writeback buffer. It does not go straight into its cache slot, because that slot still holds the previous frame's block, and nearby motion vectors may still need it.

A buffered block reaches its slot only when it is pushed out. This happens when a new block arrives while the buffer is full, or during the drain that follows an end-of-frame pulse. Blocks arrive in raster order, so pushed-out positions rise monotonically within a frame. A slot therefore still holds previous-frame data exactly when its raster index lies beyond the last position pushed out in the current frame.

A fetch is classified in one of three ways. It is a hit, answered from the cache, if it refers to the previous frame and its slot is intact. It is a miss, sent to external memory, if it refers to the previous frame but the slot was already replaced or no previous frame exists yet. It is a bypass, also sent to external memory, if it refers to an older reference frame. Three counters tally the outcomes. After the drain, the cache becomes the previous frame for the next frame.

Top module: `prevframe_cache`

## Requirements
- R1: After reset, all three outcome counters are zero and the following outputs are low: `rd_resp_valid`, `mem_rd_valid`, `mem_wr_valid` and `draining`.
- R2: A decoded-block write at (x, y) is presented on the external write port one cycle later. `mem_wr_idx` equals `y * MB_COLS + x` and `mem_wr_data` equals the written data. In cycles with no write, `mem_wr_valid` is low.
- R3: Every fetch request gets a response one cycle later. In that response exactly one of `rd_hit`, `rd_miss` and `rd_bypass` is high.
- R4: A fetch with `rd_prev = 0` (older reference) is a bypass. It raises `mem_rd_valid` with `mem_rd_idx` equal to the requested raster index, and returns `rd_data = 0`.
- R5: A fetch with `rd_prev = 1` to a slot whose raster index is beyond the last index pushed out in the current frame is a hit. It returns the data that position held at the end of the previous frame, even if the current frame's block for that position is already in the writeback buffer. `mem_rd_valid` stays low.
- R6: A fetch with `rd_prev = 1` is a miss in two cases: its raster index is at or below the last index pushed out in the current frame, or no frame has yet completed since reset. A miss raises `mem_rd_valid` with the requested index and returns `rd_data = 0`. The slot one past the last pushed-out index is still a hit.
- R7: The writeback buffer holds `WB_DEPTH` blocks. A block is pushed out into its slot only when a write arrives while the buffer is full, and the oldest block goes first. Up to `WB_DEPTH` writes into a frame, no slot is replaced.
- R8: An end-of-frame pulse with k blocks buffered keeps `draining` high for exactly k + 1 cycles while the buffer empties into the cache. After that, every slot holds the just-finished frame, which serves as the previous frame, and the pushed-out marker is cleared.
- R9: `hit_count`, `miss_count` and `bypass_count` each rise by one for every response of their class and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Decoded block write strobe |
| wr_x | input | X_W | Macroblock column of the write |
| wr_y | input | Y_W | Macroblock row of the write |
| wr_data | input | DATA_W | Decoded block content |
| frame_end | input | 1 | One-cycle pulse after the last block of a frame |
| rd_valid | input | 1 | Motion-compensation fetch request |
| rd_x | input | X_W | Macroblock column of the fetch |
| rd_y | input | Y_W | Macroblock row of the fetch |
| rd_prev | input | 1 | 1 when the fetch refers to the immediately previous frame |
| rd_resp_valid | output | 1 | Fetch response strobe |
| rd_data | output | DATA_W | Cached block on a hit, zero otherwise |
| rd_hit | output | 1 | Response answered from the cache |
| rd_miss | output | 1 | Previous-frame fetch whose slot is no longer valid |
| rd_bypass | output | 1 | Older-reference fetch |
| mem_rd_valid | output | 1 | External memory read request |
| mem_rd_idx | output | IDX_W | Raster index of the external read |
| mem_wr_valid | output | 1 | External memory write strobe |
| mem_wr_idx | output | IDX_W | Raster index of the external write |
| mem_wr_data | output | DATA_W | External write data |
| draining | output | 1 | End-of-frame flush in progress |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |
| bypass_count | output | CNT_W | Number of bypasses |

## Verification
The assertions assume three things about the inputs. Decoded blocks arrive in raster order, so pushed-out indices rise strictly within a frame. Every position of a frame is written before the end-of-frame pulse. No write, fetch or new pulse is issued while `draining` is high. The bench keeps to these rules by writing each frame as a complete raster sweep. Random fetches ride alongside the writes or fill idle cycles. The bench waits for `draining` to fall before starting the next frame, and places the pushed-out boundary and buffer-not-yet-full cases as directed fetches.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    RD_HIT    = 2'd0,
    RD_MISS   = 2'd1,
    RD_BYPASS = 2'd2
  } rd_class_e;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_DRAIN = 1'b1
  } ctl_state_e;

endpackage

// File: rtl/pfc_wbuf.sv
module pfc_wbuf #(
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic              empty,
  output logic [IDX_W-1:0]  head_idx,
  output logic [DATA_W-1:0] head_data
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0]  idx_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  logic [PTR_W-1:0] wr_ptr, wr_ptr_nxt;
  logic [PTR_W-1:0] rd_ptr, rd_ptr_nxt;
  logic [OCC_W-1:0] occ, occ_nxt;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full      = (occ == OCC_W'(DEPTH));
  assign empty     = (occ == '0);
  assign head_idx  = idx_mem[rd_ptr];
  assign head_data = data_mem[rd_ptr];

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    occ_nxt    = occ;
    if (push) wr_ptr_nxt = ptr_inc(wr_ptr);
    if (pop)  rd_ptr_nxt = ptr_inc(rd_ptr);
    case ({push, pop})
      2'b10:   occ_nxt = occ + OCC_W'(1);
      2'b01:   occ_nxt = occ - OCC_W'(1);
      default: occ_nxt = occ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      occ    <= occ_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      idx_mem[wr_ptr]  <= push_idx;
      data_mem[wr_ptr] <= push_data;
    end
  end

  // R7: a write into a full buffer must push the oldest entry out in the same cycle
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);

  // R7: nothing is pushed out of an empty buffer
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R7: occupancy never exceeds the configured depth
  p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

endmodule

// File: rtl/pfc_store.sv
module pfc_store #(
  parameter int SLOTS  = 32,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] slot_mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) slot_mem[widx] <= wdata;
    if (re) rdata <= slot_mem[ridx];
  end

endmodule

// File: rtl/pfc_judge.sv
module pfc_judge
  import pfc_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_prev,
  input  logic             prev_valid,
  input  logic             evict_any,
  input  logic [IDX_W-1:0] evict_last,
  output logic             resp_valid,
  output rd_class_e        resp_class,
  output logic [IDX_W-1:0] resp_idx,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] miss_cnt,
  output logic [CNT_W-1:0] bypass_cnt
);

  rd_class_e        cls_nxt, class_d;
  logic [IDX_W-1:0] idx_d;
  logic [CNT_W-1:0] hit_d, miss_d, bypass_d;

  always_comb begin
    if (!req_prev)
      cls_nxt = RD_BYPASS;
    else if (!prev_valid || (evict_any && (req_idx <= evict_last)))
      cls_nxt = RD_MISS;
    else
      cls_nxt = RD_HIT;
  end

  always_comb begin
    class_d  = resp_class;
    idx_d    = resp_idx;
    hit_d    = hit_cnt;
    miss_d   = miss_cnt;
    bypass_d = bypass_cnt;
    if (req_valid) begin
      class_d = cls_nxt;
      idx_d   = req_idx;
      case (cls_nxt)
        RD_HIT:  hit_d    = hit_cnt + CNT_W'(1);
        RD_MISS: miss_d   = miss_cnt + CNT_W'(1);
        default: bypass_d = bypass_cnt + CNT_W'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_class <= RD_HIT;
      resp_idx   <= '0;
      hit_cnt    <= '0;
      miss_cnt   <= '0;
      bypass_cnt <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_class <= class_d;
      resp_idx   <= idx_d;
      hit_cnt    <= hit_d;
      miss_cnt   <= miss_d;
      bypass_cnt <= bypass_d;
    end
  end

  // R9: a hit response is accompanied by exactly one increment of the hit counter
  p_hit_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_class == RD_HIT) |-> (hit_cnt == $past(hit_cnt) + CNT_W'(1)));

  // R9: without a response no counter moves
  p_quiet_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> ($stable(hit_cnt) && $stable(miss_cnt) && $stable(bypass_cnt)));

endmodule

// File: rtl/prevframe_cache.sv
module prevframe_cache
  import pfc_pkg::*;
#(
  parameter  int MB_COLS  = 8,
  parameter  int MB_ROWS  = 4,
  parameter  int WB_DEPTH = 4,
  parameter  int DATA_W   = 16,
  parameter  int CNT_W    = 16,
  localparam int SLOTS    = MB_COLS * MB_ROWS,
  localparam int IDX_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int X_W      = (MB_COLS > 1) ? $clog2(MB_COLS) : 1,
  localparam int Y_W      = (MB_ROWS > 1) ? $clog2(MB_ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [X_W-1:0]    wr_x,
  input  logic [Y_W-1:0]    wr_y,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_end,
  input  logic              rd_valid,
  input  logic [X_W-1:0]    rd_x,
  input  logic [Y_W-1:0]    rd_y,
  input  logic              rd_prev,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit,
  output logic              rd_miss,
  output logic              rd_bypass,
  output logic              mem_rd_valid,
  output logic [IDX_W-1:0]  mem_rd_idx,
  output logic              mem_wr_valid,
  output logic [IDX_W-1:0]  mem_wr_idx,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              draining,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  bypass_count
);

  function automatic logic [IDX_W-1:0] raster(input logic [Y_W-1:0] y, input logic [X_W-1:0] x);
    return IDX_W'(y) * IDX_W'(MB_COLS) + IDX_W'(x);
  endfunction

  // control state
  ctl_state_e       state, state_nxt;
  logic             prev_valid, prev_valid_nxt;
  logic             evict_any, evict_any_nxt;
  logic [IDX_W-1:0] evict_last, evict_last_nxt;

  // writeback buffer handshake
  logic              wb_push, wb_pop, wb_full, wb_empty;
  logic              evict_wr, drain_pop, swap;
  logic [IDX_W-1:0]  wb_head_idx;
  logic [DATA_W-1:0] wb_head_data;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  // external write register
  logic              xw_valid_d;
  logic [IDX_W-1:0]  xw_idx_d;
  logic [DATA_W-1:0] xw_data_d;

  logic              judge_req;
  rd_class_e         resp_class;
  logic [DATA_W-1:0] store_q;

  assign wr_idx    = raster(wr_y, wr_x);
  assign rd_idx    = raster(rd_y, rd_x);
  assign draining  = (state == ST_DRAIN);
  assign wb_push   = wr_valid && (state == ST_RUN);
  assign evict_wr  = wb_push && wb_full;
  assign drain_pop = (state == ST_DRAIN) && !wb_empty;
  assign wb_pop    = evict_wr || drain_pop;
  assign swap      = (state == ST_DRAIN) && wb_empty;
  assign judge_req = rd_valid && (state == ST_RUN);

  always_comb begin
    state_nxt      = state;
    prev_valid_nxt = prev_valid;
    evict_any_nxt  = evict_any;
    evict_last_nxt = evict_last;
    case (state)
      ST_RUN:   if (frame_end) state_nxt = ST_DRAIN;
      ST_DRAIN: if (wb_empty)  state_nxt = ST_RUN;
      default:  state_nxt = ST_RUN;
    endcase
    if (swap) begin
      prev_valid_nxt = 1'b1;
      evict_any_nxt  = 1'b0;
      evict_last_nxt = '0;
    end else if (evict_wr) begin
      evict_any_nxt  = 1'b1;
      evict_last_nxt = wb_head_idx;
    end
  end

  always_comb begin
    xw_valid_d = wb_push;
    xw_idx_d   = mem_wr_idx;
    xw_data_d  = mem_wr_data;
    if (wb_push) begin
      xw_idx_d  = wr_idx;
      xw_data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_RUN;
      prev_valid   <= 1'b0;
      evict_any    <= 1'b0;
      evict_last   <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_idx   <= '0;
      mem_wr_data  <= '0;
    end else begin
      state        <= state_nxt;
      prev_valid   <= prev_valid_nxt;
      evict_any    <= evict_any_nxt;
      evict_last   <= evict_last_nxt;
      mem_wr_valid <= xw_valid_d;
      mem_wr_idx   <= xw_idx_d;
      mem_wr_data  <= xw_data_d;
    end
  end

  pfc_wbuf #(
    .DEPTH  (WB_DEPTH),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wb_push),
    .push_idx  (wr_idx),
    .push_data (wr_data),
    .pop       (wb_pop),
    .full      (wb_full),
    .empty     (wb_empty),
    .head_idx  (wb_head_idx),
    .head_data (wb_head_data)
  );

  pfc_store #(
    .SLOTS  (SLOTS),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk   (clk),
    .we    (wb_pop),
    .widx  (wb_head_idx),
    .wdata (wb_head_data),
    .re    (judge_req),
    .ridx  (rd_idx),
    .rdata (store_q)
  );

  pfc_judge #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (judge_req),
    .req_idx    (rd_idx),
    .req_prev   (rd_prev),
    .prev_valid (prev_valid),
    .evict_any  (evict_any),
    .evict_last (evict_last),
    .resp_valid (rd_resp_valid),
    .resp_class (resp_class),
    .resp_idx   (mem_rd_idx),
    .hit_cnt    (hit_count),
    .miss_cnt   (miss_count),
    .bypass_cnt (bypass_count)
  );

  assign rd_hit       = rd_resp_valid && (resp_class == RD_HIT);
  assign rd_miss      = rd_resp_valid && (resp_class == RD_MISS);
  assign rd_bypass    = rd_resp_valid && (resp_class == RD_BYPASS);
  assign mem_rd_valid = rd_resp_valid && (resp_class != RD_HIT);
  assign rd_data      = rd_hit ? store_q : '0;

  // R3: every request accepted in run state is answered on the next cycle
  p_resp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !draining) |=> rd_resp_valid);

  // R3: a response carries exactly one outcome
  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid |-> $onehot({rd_hit, rd_miss, rd_bypass}));

  // R4: only non-hit responses go to external memory
  p_ext_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (rd_resp_valid && !rd_hit));

  // R6: a response not served from the cache returns zero data
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_resp_valid && !rd_hit) |-> (rd_data == '0));

  // R7: with raster input, pushed-out positions rise strictly within a frame
  p_evict_raster_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_wr && evict_any) |-> (wb_head_idx > evict_last));

  // R8: no traffic and no new frame pulse while the buffer is flushed
  p_quiet_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> (!wr_valid && !rd_valid && !frame_end));

  // R8: the flush ends on the cycle after the buffer is found empty
  p_drain_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && wb_empty) |=> !draining);

  // R8: after a flush the previous frame exists and no slot counts as replaced
  p_swap_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(draining) |-> (prev_valid && !evict_any));

  // R2: the external write port follows an accepted write by one cycle
  p_ext_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !draining) |=> mem_wr_valid);

endmodule

// File: tb/prevframe_cache_test.sv
module prevframe_cache_test;

  localparam int COLS  = 8;
  localparam int ROWS  = 4;
  localparam int DEPTH = 4;
  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int SLOTS = COLS * ROWS;
  localparam int XW    = 3;
  localparam int YW    = 2;
  localparam int IW    = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          wr_valid, frame_end, rd_valid, rd_prev;
  logic [XW-1:0] wr_x, rd_x;
  logic [YW-1:0] wr_y, rd_y;
  logic [DW-1:0] wr_data;
  logic          rd_resp_valid, rd_hit, rd_miss, rd_bypass;
  logic [DW-1:0] rd_data, mem_wr_data;
  logic          mem_rd_valid, mem_wr_valid, draining;
  logic [IW-1:0] mem_rd_idx, mem_wr_idx;
  logic [CW-1:0] hit_count, miss_count, bypass_count;

  prevframe_cache #(
    .MB_COLS (COLS), .MB_ROWS (ROWS), .WB_DEPTH (DEPTH), .DATA_W (DW), .CNT_W (CW)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .wr_valid (wr_valid), .wr_x (wr_x), .wr_y (wr_y), .wr_data (wr_data),
    .frame_end (frame_end),
    .rd_valid (rd_valid), .rd_x (rd_x), .rd_y (rd_y), .rd_prev (rd_prev),
    .rd_resp_valid (rd_resp_valid), .rd_data (rd_data),
    .rd_hit (rd_hit), .rd_miss (rd_miss), .rd_bypass (rd_bypass),
    .mem_rd_valid (mem_rd_valid), .mem_rd_idx (mem_rd_idx),
    .mem_wr_valid (mem_wr_valid), .mem_wr_idx (mem_wr_idx), .mem_wr_data (mem_wr_data),
    .draining (draining),
    .hit_count (hit_count), .miss_count (miss_count), .bypass_count (bypass_count)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int mcache [SLOTS];
  int qi [DEPTH];
  int qd [DEPTH];
  int qn = 0;
  bit mprev = 1'b0;
  bit ev_any = 1'b0;
  int ev_last = 0;
  int n_hit = 0, n_miss = 0, n_byp = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // 0 = hit, 1 = miss, 2 = bypass
  function automatic int classify(input int idx, input bit prev);
    if (!prev) return 2;
    if (!mprev) return 1;
    if (ev_any && idx <= ev_last) return 1;
    return 0;
  endfunction

  task automatic model_write(input int idx, input int d);
    if (qn == DEPTH) begin
      mcache[qi[0]] = qd[0];
      ev_any  = 1'b1;
      ev_last = qi[0];
      for (int j = 0; j < DEPTH - 1; j++) begin
        qi[j] = qi[j+1];
        qd[j] = qd[j+1];
      end
      qn--;
    end
    qi[qn] = idx;
    qd[qn] = d;
    qn++;
  endtask

  task automatic step(input bit w, input int widx, input int wd,
                      input bit r, input int ridx, input bit rp, input string tag);
    int    cls;
    int    edata;
    string req;
    @(negedge clk);
    wr_valid  = w;
    wr_x      = XW'(widx % COLS);
    wr_y      = YW'(widx / COLS);
    wr_data   = DW'(wd);
    rd_valid  = r;
    rd_x      = XW'(ridx % COLS);
    rd_y      = YW'(ridx / COLS);
    rd_prev   = rp;
    frame_end = 1'b0;
    cls   = classify(ridx, rp);
    edata = (cls == 0) ? mcache[ridx] : 0;
    if (r) begin
      if (cls == 0) n_hit++;
      else if (cls == 1) n_miss++;
      else n_byp++;
    end
    if (w) model_write(widx, wd);
    @(posedge clk);
    #2;
    if (tag != "") req = tag;
    else req = (cls == 0) ? "R5" : (cls == 1) ? "R6" : "R4";
    if (r) begin
      chk("R3", "resp_valid", longint'(rd_resp_valid), 1);
      chk(req, "hit", longint'(rd_hit), longint'(cls == 0));
      chk(req, "miss", longint'(rd_miss), longint'(cls == 1));
      chk(req, "bypass", longint'(rd_bypass), longint'(cls == 2));
      chk(req, "data", longint'(rd_data), longint'(edata));
      chk(req, "mem_rd_valid", longint'(mem_rd_valid), longint'(cls != 0));
      if (cls != 0) chk(req, "mem_rd_idx", longint'(mem_rd_idx), longint'(ridx));
    end else begin
      chk("R3", "no resp", longint'(rd_resp_valid), 0);
    end
    chk("R2", "mem_wr_valid", longint'(mem_wr_valid), longint'(w));
    if (w) begin
      chk("R2", "mem_wr_idx", longint'(mem_wr_idx), longint'(widx));
      chk("R2", "mem_wr_data", longint'(mem_wr_data), longint'(wd));
    end
  endtask

  task automatic end_frame();
    int k;
    int cnt;
    @(negedge clk);
    wr_valid  = 1'b0;
    rd_valid  = 1'b0;
    frame_end = 1'b1;
    k = qn;
    @(negedge clk);
    frame_end = 1'b0;
    cnt = 0;
    while (draining && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk("R8", "drain cycles", longint'(cnt), longint'(k + 1));
    for (int j = 0; j < qn; j++) mcache[qi[j]] = qd[j];
    qn     = 0;
    ev_any = 1'b0;
    mprev  = 1'b1;
  endtask

  task automatic run_frame(input int f);
    for (int i = 0; i < SLOTS; i++) begin
      int d;
      d = int'($urandom & 32'hFFFF);
      step(1'b1, i, d, 1'($urandom % 2), int'($urandom % SLOTS), ($urandom % 4) != 0, "");
      if ($urandom % 4 == 0)
        step(1'b0, 0, 0, 1'b1, int'($urandom % SLOTS), 1'($urandom % 2), "");
      if (f == 1 && i == DEPTH - 1) begin
        // R7: buffer just full, nothing replaced yet
        step(1'b0, 0, 0, 1'b1, 0, 1'b1, "R7");
        chk("R7", "slot0 intact", longint'(rd_hit), 1);
      end
      if (f == 1 && i == DEPTH) begin
        // R7: first push-out replaced slot 0 only
        step(1'b0, 0, 0, 1'b1, 0, 1'b1, "R7");
        chk("R7", "slot0 replaced", longint'(rd_miss), 1);
        step(1'b0, 0, 0, 1'b1, 1, 1'b1, "R7");
        chk("R7", "slot1 intact", longint'(rd_hit), 1);
      end
      if (f == 2 && i == 20) begin
        // R6: boundary at the last pushed-out index
        step(1'b0, 0, 0, 1'b1, ev_last, 1'b1, "R6");
        chk("R6", "at boundary miss", longint'(rd_miss), 1);
        step(1'b0, 0, 0, 1'b1, ev_last + 1, 1'b1, "R6");
        chk("R6", "past boundary hit", longint'(rd_hit), 1);
      end
      if (f == 2 && i == 25) begin
        // R5: block just buffered, slot still holds previous frame
        step(1'b0, 0, 0, 1'b1, 25, 1'b1, "R5");
        chk("R5", "buffered slot hit", longint'(rd_hit), 1);
      end
    end
    end_frame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    wr_valid = 1'b0; frame_end = 1'b0; rd_valid = 1'b0; rd_prev = 1'b0;
    wr_x = '0; wr_y = '0; wr_data = '0; rd_x = '0; rd_y = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "hit_count", longint'(hit_count), 0);
    chk("R1", "miss_count", longint'(miss_count), 0);
    chk("R1", "bypass_count", longint'(bypass_count), 0);
    chk("R1", "rd_resp_valid", longint'(rd_resp_valid), 0);
    chk("R1", "mem_rd_valid", longint'(mem_rd_valid), 0);
    chk("R1", "mem_wr_valid", longint'(mem_wr_valid), 0);
    chk("R1", "draining", longint'(draining), 0);

    // R6: before any complete frame every previous-frame fetch misses
    step(1'b0, 0, 0, 1'b1, 9, 1'b1, "R6");
    chk("R6", "no previous frame", longint'(rd_miss), 1);
    // R4: older reference always bypasses
    step(1'b0, 0, 0, 1'b1, 31, 1'b0, "R4");

    for (int f = 0; f < 4; f++) begin
      run_frame(f);
      if (f == 2) begin
        // R8: flush of an empty buffer takes one cycle, cache content kept
        end_frame();
        step(1'b0, 0, 0, 1'b1, 30, 1'b1, "R8");
        chk("R8", "content after empty flush", longint'(rd_hit), 1);
      end
    end

    @(negedge clk);
    wr_valid = 1'b0;
    rd_valid = 1'b0;
    @(negedge clk);
    chk("R9", "hit_count", longint'(hit_count), longint'(n_hit));
    chk("R9", "miss_count", longint'(miss_count), longint'(n_miss));
    chk("R9", "bypass_count", longint'(bypass_count), longint'(n_byp));

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule